// File: doc/BRIEF.md
# Posted Register-Write Bridge with Pending Tracking

This block sits between a fast bus clock domain and a slower functional clock domain that holds a timer's configuration registers. A write to one of the ten functional-side registers is captured on the bus side and handed over through a per-register toggle handshake. Each register gets a one-cycle update strobe on the functional side. Until the functional side has taken the value and its acknowledge has crossed back, the register's bit in a read-only write-pending word stays set. A few direct registers (identification, a scratch configuration word, an interrupt-enable word, interface control and system status) live entirely in the bus domain and need no handshake.

In posted mode, the reset default, every write completes in the cycle it is presented. A write to a register whose earlier update is still in flight is discarded. In non-posted mode a write to a functional-side register stalls the bus until the acknowledge has returned. Software can also request a soft reset. It clears the functional registers and the bus-side state, and a status bit shows when the reset has finished.

Top module: `posted_write_bridge`

## Requirements
- R1: Functional register k (k = 0..9) sits at byte address 0x40 + 4k and owns bit k of the pending word at byte address 0x14. That bit reads 1 from the bus edge that accepts a write to register k.
- R2: Each accepted write makes `fn_wr_stb[k]` pulse for exactly one functional clock cycle and loads the value into `fn_regs[32k+31:32k]`. The pending bit clears only after that update has been acknowledged back across the domains.
- R3: In posted mode `bus_ready` is 1 for every write. A write to a register whose pending bit is set is discarded: no strobe, and the functional value and readback keep the earlier write.
- R4: Reading functional register k returns the last acknowledged value. While bit k is pending, the read returns the previous value.
- R5: In non-posted mode, `bus_ready` stays 0 on a functional-register write until its acknowledge has returned. When the write completes, the pending bit is clear and `fn_regs` already holds the new value.
- R6: Bit 2 of the interface-control register at 0x0C selects posted mode (1) and resets to 1. Writes set it from bit 2 of the data.
- R7: Writing 1 to bit 1 of 0x0C starts a soft reset, and bit 0 of the status register at 0x10 reads 0 until the functional side has acknowledged it, then 1. The soft reset clears all functional registers, their readbacks, 0x04 and 0x08, and sets posted mode. Functional-register writes during the reset are dropped.
- R8: The identification word (0x00, read-only), configuration (0x04) and interrupt-enable (0x08) registers are accessed directly, with no stall and no pending bit.
- R9: The pending word is read-only, and writes to 0x14 leave it unchanged.
- R10: After reset the pending word is 0, status reads 1, interface control reads 0x4, configuration reads 0 and every functional register is 0.
- R11: A soft-reset request made while any pending bit is set is ignored, and bit 2 of that write still updates the posted-mode setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side asynchronous reset, active low |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address, word aligned |
| bus_wdata | input | DW (32) | Write data |
| bus_ready | output | 1 | Access completes on a clock edge where valid and ready are both 1 |
| bus_rdata | output | DW (32) | Read data, valid while a read is presented |
| fn_clk | input | 1 | Functional-side clock |
| fn_rst_n | input | 1 | Functional-side asynchronous reset, active low |
| fn_regs | output | NREG*DW (320) | Functional register values, register k in bits 32k+31:32k |
| fn_wr_stb | output | NREG (10) | One-cycle update strobe per functional register |

## Verification
The embedded assertions check every cycle that an accepted posted write raises its pending bit, that a write to a busy register leaves its captured value and toggle unchanged, and that a pending bit falls only once the returned acknowledge matches the request. They also check that non-posted writes stall while the target is busy, that update strobes are single pulses, and that a soft reset leaves the functional side all zero. Other behaviours need whole transactions crossing both clocks, and only the bench's scenarios show them. These are the stale-then-fresh readback, the number of strobes per write, the value that survives a dropped write, the length of a non-posted stall and the status sequence of a soft reset.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    // Selector of the direct (bus-domain only) registers, bus_addr[4:2]
    typedef enum logic [2:0] {
        DIR_IDENT  = 3'd0,
        DIR_CONFIG = 3'd1,
        DIR_IRQEN  = 3'd2,
        DIR_IFCTL  = 3'd3,
        DIR_SYSST  = 3'd4,
        DIR_PEND   = 3'd5
    } dir_sel_e;

    localparam int unsigned IFCTL_SRST_BIT   = 1;
    localparam int unsigned IFCTL_POSTED_BIT = 2;
    localparam int unsigned SLOT_W           = 4;   // addr[5:2] slot index

endpackage

// File: rtl/pwt_sync2.sv
module pwt_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sy_st_t;

    sy_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = d;
        s_d.sync = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.sync;
endmodule

// File: rtl/pwt_bus_side.sv
module pwt_bus_side
    import pwt_pkg::*;
#(
    parameter int unsigned NREG     = 10,
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 8,
    parameter logic [31:0] ID_VALUE = 32'h5057_0A01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic               ready,
    output logic [DW-1:0]      rdata,
    output logic [NREG-1:0]    req_tog,
    output logic               rst_tog,
    output logic [NREG*DW-1:0] hold_flat,
    input  logic [NREG-1:0]    ack_sync,
    input  logic               rst_ack_sync
);
    localparam int unsigned RGN_W = AW - 6;

    typedef struct packed {
        logic [NREG-1:0]         pend;
        logic [NREG-1:0]         req_tog;
        logic                    rst_tog;
        logic [NREG-1:0][DW-1:0] hold;
        logic [NREG-1:0][DW-1:0] mirror;
        logic [DW-1:0]           cfg;
        logic [DW-1:0]           irq_en;
        logic                    posted;
        logic                    wait_np;
    } bus_st_t;

    bus_st_t s_d, s_q;

    logic              aligned, sync_hit, dir_hit, rst_busy, sel_pend, blocked;
    logic              launch_hit, rst_launch;
    logic [SLOT_W-1:0] sidx;
    logic [DW-1:0]     sel_mirror;
    dir_sel_e          dsel;

    assign aligned  = (addr[1:0] == 2'b00);
    assign sidx     = addr[5:2];
    assign sync_hit = aligned && (addr[AW-1:6] == RGN_W'(1)) && (int'(sidx) < NREG);
    assign dir_hit  = aligned && (addr[AW-1:6] == '0) && !addr[5];
    assign dsel     = dir_sel_e'(addr[4:2]);
    assign rst_busy = (s_q.rst_tog != rst_ack_sync);

    always_comb begin
        sel_pend   = 1'b0;
        sel_mirror = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sync_hit && sidx == SLOT_W'(i)) begin
                sel_pend   = s_q.pend[i];
                sel_mirror = s_q.mirror[i];
            end
        end
    end

    assign blocked = sel_pend || rst_busy;

    always_comb begin
        s_d        = s_q;
        ready      = 1'b1;
        rdata      = '0;
        launch_hit = 1'b0;
        rst_launch = 1'b0;

        // retire acknowledged transfers
        for (int i = 0; i < NREG; i++) begin
            if (s_q.pend[i] && (ack_sync[i] == s_q.req_tog[i])) begin
                s_d.pend[i]   = 1'b0;
                s_d.mirror[i] = s_q.hold[i];
            end
        end

        // writes to functional-side registers
        if (valid && we && sync_hit) begin
            if (s_q.posted) begin
                launch_hit = !blocked;
            end else if (s_q.wait_np) begin
                ready = !sel_pend;
                if (!sel_pend) s_d.wait_np = 1'b0;
            end else begin
                ready = 1'b0;
                if (!blocked) begin
                    launch_hit  = 1'b1;
                    s_d.wait_np = 1'b1;
                end
            end
        end

        if (launch_hit) begin
            for (int i = 0; i < NREG; i++) begin
                if (sidx == SLOT_W'(i)) begin
                    s_d.pend[i]    = 1'b1;
                    s_d.req_tog[i] = ~s_q.req_tog[i];
                    s_d.hold[i]    = wdata;
                end
            end
        end

        // writes to direct registers
        if (valid && we && dir_hit) begin
            case (dsel)
                DIR_CONFIG: s_d.cfg    = wdata;
                DIR_IRQEN:  s_d.irq_en = wdata;
                DIR_IFCTL: begin
                    if (wdata[IFCTL_SRST_BIT] && (s_q.pend == '0) && !rst_busy) begin
                        rst_launch  = 1'b1;
                        s_d.rst_tog = ~s_q.rst_tog;
                        s_d.cfg     = '0;
                        s_d.irq_en  = '0;
                        s_d.posted  = 1'b1;
                        s_d.hold    = '0;
                        s_d.mirror  = '0;
                    end else begin
                        s_d.posted = wdata[IFCTL_POSTED_BIT];
                    end
                end
                default: ;
            endcase
        end

        // reads
        if (valid && !we) begin
            if (sync_hit) begin
                rdata = sel_mirror;
            end else if (dir_hit) begin
                case (dsel)
                    DIR_IDENT:  rdata = DW'(ID_VALUE);
                    DIR_CONFIG: rdata = s_q.cfg;
                    DIR_IRQEN:  rdata = s_q.irq_en;
                    DIR_IFCTL:  rdata[IFCTL_POSTED_BIT] = s_q.posted;
                    DIR_SYSST:  rdata[0] = !rst_busy;
                    DIR_PEND:   rdata = DW'(s_q.pend);
                    default:    rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.posted <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_tog   = s_q.req_tog;
    assign rst_tog   = s_q.rst_tog;
    assign hold_flat = s_q.hold;

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R1
        pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && we && ready && sync_hit && sidx == SLOT_W'(g) && s_q.posted
             && !s_q.pend[g] && !rst_busy) |=> s_q.pend[g]);
        // R3
        drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && we && sync_hit && sidx == SLOT_W'(g) && s_q.posted && s_q.pend[g])
            |=> ($stable(s_q.hold[g]) && $stable(s_q.req_tog[g])));
        // R2
        pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(s_q.pend[g]) |-> $past(ack_sync[g] == s_q.req_tog[g]));
    end

    // R5
    np_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && we && sync_hit && !s_q.posted && blocked) |-> !ready);
    // R7
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_launch |=> (s_q.posted && s_q.cfg == '0 && s_q.pend == '0 && s_q.mirror == '0));
endmodule

// File: rtl/pwt_fn_bank.sv
module pwt_fn_bank #(
    parameter int unsigned NREG = 10,
    parameter int unsigned DW   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG-1:0]    req_sync,
    input  logic               rst_sync,
    input  logic [NREG*DW-1:0] hold_flat,
    output logic [NREG-1:0]    ack_tog,
    output logic               rst_ack,
    output logic [NREG*DW-1:0] regs_flat,
    output logic [NREG-1:0]    stb
);
    typedef struct packed {
        logic [NREG-1:0]         seen;
        logic                    rst_seen;
        logic [NREG-1:0][DW-1:0] regs;
        logic [NREG-1:0]         stb;
    } fn_st_t;

    fn_st_t          s_d, s_q;
    logic [NREG-1:0] upd;
    logic            rst_hit;

    assign upd     = req_sync ^ s_q.seen;
    assign rst_hit = rst_sync ^ s_q.rst_seen;

    always_comb begin
        s_d          = s_q;
        s_d.seen     = req_sync;
        s_d.rst_seen = rst_sync;
        s_d.stb      = '0;
        if (rst_hit) s_d.regs = '0;
        for (int i = 0; i < NREG; i++) begin
            if (upd[i]) begin
                s_d.regs[i] = hold_flat[i*DW +: DW];
                s_d.stb[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ack_tog   = s_q.seen;
    assign rst_ack   = s_q.rst_seen;
    assign regs_flat = s_q.regs;
    assign stb       = s_q.stb;

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R2
        stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.stb[g] |=> !s_q.stb[g]);
    end

    // R7
    srst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_hit && upd == '0) |=> (s_q.regs == '0));
endmodule

// File: rtl/posted_write_bridge.sv
module posted_write_bridge #(
    parameter int unsigned NREG     = 10,
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 8,
    parameter logic [31:0] ID_VALUE = 32'h5057_0A01
) (
    input  logic               bus_clk,
    input  logic               bus_rst_n,
    input  logic               bus_valid,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic               bus_ready,
    output logic [DW-1:0]      bus_rdata,
    input  logic               fn_clk,
    input  logic               fn_rst_n,
    output logic [NREG*DW-1:0] fn_regs,
    output logic [NREG-1:0]    fn_wr_stb
);
    localparam int unsigned CH = NREG + 1;   // register channels plus soft reset

    logic [NREG-1:0]    req_tog, ack_tog;
    logic               rst_tog, rst_ack;
    logic [NREG*DW-1:0] hold_flat;
    logic [CH-1:0]      req_fn, ack_bus;

    pwt_bus_side #(.NREG(NREG), .DW(DW), .AW(AW), .ID_VALUE(ID_VALUE)) u_bus (
        .clk          (bus_clk),
        .rst_n        (bus_rst_n),
        .valid        (bus_valid),
        .we           (bus_we),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .ready        (bus_ready),
        .rdata        (bus_rdata),
        .req_tog      (req_tog),
        .rst_tog      (rst_tog),
        .hold_flat    (hold_flat),
        .ack_sync     (ack_bus[NREG-1:0]),
        .rst_ack_sync (ack_bus[NREG])
    );

    pwt_sync2 #(.W(CH)) u_req_sync (
        .clk   (fn_clk),
        .rst_n (fn_rst_n),
        .d     ({rst_tog, req_tog}),
        .q     (req_fn)
    );

    pwt_fn_bank #(.NREG(NREG), .DW(DW)) u_fn (
        .clk       (fn_clk),
        .rst_n     (fn_rst_n),
        .req_sync  (req_fn[NREG-1:0]),
        .rst_sync  (req_fn[NREG]),
        .hold_flat (hold_flat),
        .ack_tog   (ack_tog),
        .rst_ack   (rst_ack),
        .regs_flat (fn_regs),
        .stb       (fn_wr_stb)
    );

    pwt_sync2 #(.W(CH)) u_ack_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     ({rst_ack, ack_tog}),
        .q     (ack_bus)
    );
endmodule

// File: tb/posted_write_bridge_tb.sv
module posted_write_bridge_tb;
    localparam int NREG = 10;
    localparam int DW   = 32;
    localparam logic [7:0] A_ID = 8'h00, A_CFG = 8'h04, A_IRQ = 8'h08,
                           A_IFC = 8'h0C, A_SYS = 8'h10, A_PEND = 8'h14;

    logic             bus_clk = 0, fn_clk = 0, bus_rst_n = 0, fn_rst_n = 0;
    logic             bus_valid = 0, bus_we = 0, bus_ready;
    logic [7:0]       bus_addr = 0;
    logic [DW-1:0]    bus_wdata = 0, bus_rdata;
    logic [NREG*DW-1:0] fn_regs;
    logic [NREG-1:0]  fn_wr_stb;

    int n_chk = 0, n_fail = 0;
    int stb_cnt [NREG];
    bit done = 0;

    always #2.5 bus_clk = ~bus_clk;
    always #8.5 fn_clk  = ~fn_clk;

    posted_write_bridge u_dut (.*);

    always @(negedge fn_clk) begin
        for (int k = 0; k < NREG; k++) if (fn_wr_stb[k]) stb_cnt[k]++;
    end

    function automatic logic [7:0] ra(input int k);
        return 8'(8'h40 + 4 * k);
    endfunction

    function automatic logic [31:0] fv(input int k);
        return fn_regs[k*DW +: DW];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d, output int stalls);
        stalls = 0;
        bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_ready) begin @(negedge bus_clk); #1; stalls++; end
        @(posedge bus_clk); @(negedge bus_clk);
        bus_valid = 0; bus_we = 0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1; bus_we = 0; bus_addr = a;
        #1; d = bus_rdata;
        @(posedge bus_clk); @(negedge bus_clk);
        bus_valid = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int t = 0; t < 300; t++) begin
            brd(A_PEND, v);
            if (v == 0) break;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge bus_clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, w;
        int st;
        for (int k = 0; k < NREG; k++) stb_cnt[k] = 0;
        repeat (4) @(negedge fn_clk);
        bus_rst_n = 1; fn_rst_n = 1;
        @(negedge bus_clk);

        // R10 reset state
        brd(A_PEND, v); chk(v == 0, "R10 pend", v, 0);
        brd(A_SYS, v);  chk(v == 1, "R10 status", v, 1);
        brd(A_IFC, v);  chk(v == 4, "R10 ifctl R6", v, 4);
        brd(A_ID, v);   chk(v == 32'h5057_0A01, "R10 ident", v, 32'h5057_0A01);
        brd(A_CFG, v);  chk(v == 0, "R10 cfg", v, 0);
        chk(fn_regs == '0, "R10 fn_regs", fn_regs[31:0], 0);

        // Sweep every functional register in posted mode: R1 R2 R3 R4
        for (int k = 0; k < NREG; k++) begin
            w = 32'hA500_0000 + 32'(k) * 32'h1111;
            bwr(ra(k), w, st);
            chk(st == 0, "R3 posted no stall", st, 0);
            brd(A_PEND, v); chk(v == (32'd1 << k), "R1 pend bit", v, 32'd1 << k);
            brd(ra(k), v);  chk(v == 0, "R4 stale read", v, 0);
            wait_idle();
            chk(fv(k) == w, "R2 fn value", fv(k), w);
            chk(stb_cnt[k] == 1, "R2 one strobe", stb_cnt[k], 1);
            brd(ra(k), v);  chk(v == w, "R4 fresh read", v, w);
        end

        // R3 drop of a write to a pending register
        bwr(ra(3), 32'h1234_5678, st);
        bwr(ra(3), 32'hDEAD_BEEF, st);
        wait_idle();
        chk(fv(3) == 32'h1234_5678, "R3 drop fn", fv(3), 32'h1234_5678);
        brd(ra(3), v); chk(v == 32'h1234_5678, "R3 drop read", v, 32'h1234_5678);
        chk(stb_cnt[3] == 2, "R3 drop strobes", stb_cnt[3], 2);

        // R1 two registers in flight together
        bwr(ra(4), 32'h4444, st);
        bwr(ra(5), 32'h5555, st);
        brd(A_PEND, v); chk(v == 32'h30, "R1 two pending", v, 32'h30);
        wait_idle();

        // R9 pending word read-only
        bwr(A_PEND, 32'h3FF, st);
        brd(A_PEND, v); chk(v == 0, "R9 idle", v, 0);
        bwr(ra(2), 32'h2222, st);
        bwr(A_PEND, 32'h0, st);
        brd(A_PEND, v); chk(v == 32'h4, "R9 busy", v, 4);
        wait_idle();

        // R8 direct registers
        bwr(A_CFG, 32'hC0FF_EE00, st); chk(st == 0, "R8 cfg no stall", st, 0);
        bwr(A_IRQ, 32'h0000_0007, st);
        bwr(A_ID, 32'h0, st);
        brd(A_CFG, v); chk(v == 32'hC0FF_EE00, "R8 cfg", v, 32'hC0FF_EE00);
        brd(A_IRQ, v); chk(v == 7, "R8 irq", v, 7);
        brd(A_ID, v);  chk(v == 32'h5057_0A01, "R8 ident ro", v, 32'h5057_0A01);
        brd(A_PEND, v); chk(v == 0, "R8 no pend", v, 0);

        // R5 R6 non-posted mode
        bwr(A_IFC, 32'h0, st);
        brd(A_IFC, v); chk(v == 0, "R6 cleared", v, 0);
        bwr(ra(7), 32'h7777_0007, st);
        chk(st >= 4, "R5 stall", st, 4);
        chk(fv(7) == 32'h7777_0007, "R5 fn done", fv(7), 32'h7777_0007);
        brd(A_PEND, v); chk(v == 0, "R5 pend clear", v, 0);
        brd(ra(7), v); chk(v == 32'h7777_0007, "R5 read", v, 32'h7777_0007);
        bwr(A_IFC, 32'h4, st);
        brd(A_IFC, v); chk(v == 4, "R6 set", v, 4);

        // R11 soft reset refused while a write is pending
        bwr(ra(0), 32'h0BAD_0000, st);
        bwr(A_IFC, 32'h6, st);
        brd(A_SYS, v); chk(v == 1, "R11 ignored", v, 1);
        brd(A_CFG, v); chk(v == 32'hC0FF_EE00, "R11 cfg kept", v, 32'hC0FF_EE00);
        wait_idle();

        // R7 soft reset
        bwr(A_IFC, 32'h2, st);
        bwr(ra(6), 32'h6666_6666, st);
        brd(A_PEND, v); chk(v == 0, "R7 write dropped", v, 0);
        brd(A_SYS, v);  chk(v == 0, "R7 busy", v, 0);
        brd(A_CFG, v);  chk(v == 0, "R7 cfg", v, 0);
        brd(A_IRQ, v);  chk(v == 0, "R7 irq", v, 0);
        brd(A_IFC, v);  chk(v == 4, "R7 posted", v, 4);
        for (int t = 0; t < 300; t++) begin
            brd(A_SYS, v);
            if (v == 1) break;
        end
        chk(v == 1, "R7 done", v, 1);
        chk(fn_regs == '0, "R7 fn cleared", fv(0), 0);
        brd(ra(0), v); chk(v == 0, "R7 readback", v, 0);
        chk(stb_cnt[6] == 1, "R7 no strobe", stb_cnt[6], 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule